// File: doc/BRIEF.md
# Low Pin Count Cycle Monitor

This block watches a Low Pin Count bus without driving it. On every rising clock edge it samples the active-low frame strobe and the 4-bit address/data nibble bus. It then steps through the phases of a cycle: start, cycle kind, address, turnaround, sync, data and a second turnaround.

When an I/O or memory cycle finishes, it presents one record for one clock. The record holds the start code, the cycle kind, the address, the data byte, the final sync code and a two-bit status. Sticky flags report protocol violations until reset. A programmable limit bounds how long the sync phase may wait.

The block is used as a bus probe in verification or debug logic. The bus reset, active low, clears all state.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: While `rst_n` is low and after it is released, every output is zero until bus activity is decoded.
- R2: When `frame_n` is sampled low while idle, a cycle begins. The start code is the nibble on the last clock with `frame_n` low. The nibble on the first clock with `frame_n` high is the cycle kind, and bits [3:1] of that nibble become `rec_kind`.
- R3: If the nibble differs between two consecutive clocks while `frame_n` stays low, `flag_start_glitch` is set and stays set.
- R4: A start code of 4'b1111 ends the cycle, and no record is produced.
- R5: A kind nibble whose bits [3:2] are 2'b11 sets `flag_bad_kind` and abandons the cycle with no record. Kind codes 3'b100 and 3'b101 (DMA) return to idle with no record. Only kinds 3'b000 to 3'b011 produce records.
- R6: I/O kinds (`rec_kind[1]` = 0) take 4 address nibbles and give a zero-extended 16-bit address. Memory kinds take 8 address nibbles. In both cases the most significant nibble comes first.
- R7: Each turnaround phase lasts 2 clocks. Any nibble other than 4'b1111 in a turnaround sets `flag_turn`, which is sticky.
- R8: In the sync phase, 4'b0101 and 4'b0110 mean wait, and the monitor stays in the phase. Any other value ends the phase and is reported as `rec_sync`. Values other than 4'b0000, 4'b1001 and 4'b1010 also set the sticky `flag_sync_rsvd`.
- R9: Up to `wait_limit` wait nibbles in one sync phase are accepted. The next wait nibble after that sets the sticky `flag_timeout` and abandons the cycle with no record.
- R10: The data byte arrives over 2 clocks, low nibble first.
- R11: `rec_valid` is high for exactly one clock, starting at the edge that samples the second clock of the final turnaround. `rec_status[0]` is set when the sync code was 4'b1010. `rec_status[1]` is set when a turnaround nibble in this cycle was not 4'b1111.
- R12: If `frame_n` is sampled low in any phase after the start phase, the current cycle is discarded and decoding restarts with that nibble as a start candidate. This applies even on the last turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Bus reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| nib | input | 4 | Sampled address/data/control nibble |
| wait_limit | input | WAIT_W | Maximum accepted wait nibbles per sync phase |
| rec_valid | output | 1 | One-clock record strobe |
| rec_start | output | 4 | Start code of the recorded cycle |
| rec_kind | output | 3 | Cycle kind (kind nibble bits [3:1]) |
| rec_addr | output | 32 | Assembled address |
| rec_data | output | 8 | Data byte |
| rec_sync | output | 4 | Final sync code |
| rec_status | output | 2 | {turnaround fault, sync error} |
| flag_start_glitch | output | 1 | Sticky: nibble changed while frame held low |
| flag_bad_kind | output | 1 | Sticky: disallowed cycle kind |
| flag_turn | output | 1 | Sticky: turnaround nibble not 4'b1111 |
| flag_sync_rsvd | output | 1 | Sticky: reserved sync code |
| flag_timeout | output | 1 | Sticky: sync wait exceeded limit |

## Verification
The completion of a record and a restart caused by the frame strobe can fall on the same clock: the final turnaround sample. The bench provokes this by pulling `frame_n` low exactly on that clock and starting a new cycle there. The scoreboard then requires that the interrupted cycle yields no record and that the following cycle is reported intact. A second collision checks a wait-limit boundary. Exactly `wait_limit` waits must still complete normally, and one more wait must abort the cycle.

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        nib,
  input  logic [WAIT_W-1:0] wait_limit,
  output logic              rec_valid,
  output logic [3:0]        rec_start,
  output logic [2:0]        rec_kind,
  output logic [31:0]       rec_addr,
  output logic [7:0]        rec_data,
  output logic [3:0]        rec_sync,
  output logic [1:0]        rec_status,
  output logic              flag_start_glitch,
  output logic              flag_bad_kind,
  output logic              flag_turn,
  output logic              flag_sync_rsvd,
  output logic              flag_timeout
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_TAR1, S_SYNC, S_DATA, S_TAR2
  } phase_t;

  phase_t            state;
  logic [3:0]        start_nib;
  logic [2:0]        kind;
  logic [31:0]       addr;
  logic [7:0]        data;
  logic [3:0]        sync_code;
  logic [2:0]        cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic              turn_bad;

  wire is_wait   = (nib == 4'b0101) || (nib == 4'b0110);
  wire sync_ok   = (nib == 4'b0000) || (nib == 4'b1001) || (nib == 4'b1010);
  wire [2:0] addr_last = kind[1] ? 3'd7 : 3'd3;
  wire nib_turn_bad = (nib != 4'b1111);
  wire busy = (state != S_IDLE) && (state != S_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      start_nib <= '0;
      kind <= '0;
      addr <= '0;
      data <= '0;
      sync_code <= '0;
      cnt <= '0;
      wait_cnt <= '0;
      turn_bad <= 1'b0;
      rec_valid <= 1'b0;
      rec_start <= '0;
      rec_kind <= '0;
      rec_addr <= '0;
      rec_data <= '0;
      rec_sync <= '0;
      rec_status <= '0;
      flag_start_glitch <= 1'b0;
      flag_bad_kind <= 1'b0;
      flag_turn <= 1'b0;
      flag_sync_rsvd <= 1'b0;
      flag_timeout <= 1'b0;
    end else begin
      rec_valid <= 1'b0;
      if (busy && !frame_n) begin
        state <= S_START;
        start_nib <= nib;
      end else begin
        case (state)
          S_IDLE: if (!frame_n) begin
            state <= S_START;
            start_nib <= nib;
          end
          S_START: begin
            if (!frame_n) begin
              if (nib != start_nib) flag_start_glitch <= 1'b1;
              start_nib <= nib;
            end else if (start_nib == 4'b1111) begin
              state <= S_IDLE;
            end else begin
              kind <= nib[3:1];
              addr <= '0;
              cnt <= '0;
              turn_bad <= 1'b0;
              if (nib[3:2] == 2'b11) begin
                flag_bad_kind <= 1'b1;
                state <= S_IDLE;
              end else if (nib[3]) begin
                state <= S_IDLE;
              end else begin
                state <= S_ADDR;
              end
            end
          end
          S_ADDR: begin
            addr <= {addr[27:0], nib};
            if (cnt == addr_last) begin
              cnt <= '0;
              state <= S_TAR1;
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          S_TAR1: begin
            if (nib_turn_bad) begin
              flag_turn <= 1'b1;
              turn_bad <= 1'b1;
            end
            if (cnt == 3'd1) begin
              cnt <= '0;
              wait_cnt <= '0;
              state <= S_SYNC;
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          S_SYNC: begin
            if (is_wait) begin
              if (wait_cnt == wait_limit) begin
                flag_timeout <= 1'b1;
                state <= S_IDLE;
              end else begin
                wait_cnt <= wait_cnt + 1'b1;
              end
            end else begin
              sync_code <= nib;
              if (!sync_ok) flag_sync_rsvd <= 1'b1;
              cnt <= '0;
              state <= S_DATA;
            end
          end
          S_DATA: begin
            if (cnt == 3'd0) begin
              data[3:0] <= nib;
              cnt <= 3'd1;
            end else begin
              data[7:4] <= nib;
              cnt <= '0;
              state <= S_TAR2;
            end
          end
          S_TAR2: begin
            if (nib_turn_bad) flag_turn <= 1'b1;
            if (cnt == 3'd1) begin
              cnt <= '0;
              state <= S_IDLE;
              rec_valid <= 1'b1;
              rec_start <= start_nib;
              rec_kind <= kind;
              rec_addr <= addr;
              rec_data <= data;
              rec_sync <= sync_code;
              rec_status <= {turn_bad | nib_turn_bad, sync_code == 4'b1010};
            end else begin
              if (nib_turn_bad) turn_bad <= 1'b1;
              cnt <= cnt + 3'd1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);
  a_r5_record_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !rec_kind[2]);
  a_r6_io_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_kind[1]) |-> (rec_addr[31:16] == 16'h0));
  a_r4_no_abort_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_start != 4'b1111));
  a_r3_glitch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_start_glitch |=> flag_start_glitch);
  a_r7_turn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_turn |=> flag_turn);
  a_r8_rsvd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sync_rsvd |=> flag_sync_rsvd);
  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_timeout |=> flag_timeout);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && frame_n) |=> (state == S_IDLE));
  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_n) |=> (state == S_START && !rec_valid));

endmodule

// File: tb/test_lpc_cycle_monitor.sv
module test_lpc_cycle_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  nib = 4'hF;
  logic [7:0]  wait_limit = 8'd20;
  logic        rec_valid;
  logic [3:0]  rec_start;
  logic [2:0]  rec_kind;
  logic [31:0] rec_addr;
  logic [7:0]  rec_data;
  logic [3:0]  rec_sync;
  logic [1:0]  rec_status;
  logic f_glitch, f_kind, f_turn, f_rsvd, f_tout;

  int checks = 0;
  int failures = 0;
  int nrec = 0;
  bit done = 0;
  logic [52:0] expq[$];

  always #4 clk = ~clk;

  lpc_cycle_monitor #(.WAIT_W(8)) i_lpc_cycle_monitor (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib(nib), .wait_limit(wait_limit),
    .rec_valid(rec_valid), .rec_start(rec_start), .rec_kind(rec_kind),
    .rec_addr(rec_addr), .rec_data(rec_data), .rec_sync(rec_sync),
    .rec_status(rec_status), .flag_start_glitch(f_glitch), .flag_bad_kind(f_kind),
    .flag_turn(f_turn), .flag_sync_rsvd(f_rsvd), .flag_timeout(f_tout));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      nrec++;
      if (expq.size() == 0) begin
        chk("R4/R5/R9/R12 unexpected record", {11'd0, rec_start, rec_kind, rec_addr,
            rec_data, rec_sync, rec_status}, 64'h0);
      end else begin
        chk("R2/R6/R8/R10/R11 record", {11'd0, rec_start, rec_kind, rec_addr, rec_data,
            rec_sync, rec_status}, {11'd0, expq.pop_front()});
      end
    end
  end

  task automatic step(input logic fr, input logic [3:0] n);
    @(negedge clk);
    frame_n = fr;
    nib = n;
  endtask

  task automatic run_cycle(input logic [3:0] st, input logic [2:0] kind, input logic [31:0] a,
                           input logic [7:0] d, input int waits, input logic [3:0] sv,
                           input logic [3:0] tv, input bit push, input bit finish);
    int n;
    logic [31:0] ea;
    n = kind[1] ? 8 : 4;
    ea = kind[1] ? a : {16'h0, a[15:0]};
    if (push) expq.push_back({st, kind, ea, d, sv, (tv != 4'hF), (sv == 4'hA)});
    step(1'b0, st);
    step(1'b1, {kind, 1'b0});
    for (int i = 0; i < n; i++) step(1'b1, a[(n-1-i)*4 +: 4]);
    step(1'b1, tv);
    step(1'b1, 4'hF);
    for (int i = 0; i < waits; i++) step(1'b1, (i % 2) ? 4'h6 : 4'h5);
    step(1'b1, sv);
    step(1'b1, d[3:0]);
    step(1'b1, d[7:4]);
    step(1'b1, 4'hF);
    if (finish) begin
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rec_valid, rec_start, rec_kind, rec_addr, rec_data, rec_sync,
        rec_status, f_glitch, f_kind, f_turn, f_rsvd, f_tout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {rec_valid, f_glitch, f_kind, f_turn, f_rsvd, f_tout}, 0);

    // R6 I/O write, 16-bit address; R10 data low nibble first
    run_cycle(4'h0, 3'b001, 32'hFFFF1234, 8'hA5, 0, 4'h0, 4'hF, 1, 1);
    // R2/R3 start held low with a constant nibble: no glitch; R8 waits; R6 memory read
    step(1'b0, 4'h0); step(1'b0, 4'h0);
    run_cycle(4'h0, 3'b010, 32'hDEADBEEF, 8'h3C, 3, 4'h0, 4'hF, 1, 1);
    chk("R3 no glitch on steady start", f_glitch, 0);
    chk("R7 no turn flag yet", f_turn, 0);
    // R11 sync error reported in status bit 0; R8 memory write
    run_cycle(4'h0, 3'b011, 32'h80000010, 8'h5A, 1, 4'hA, 4'hF, 1, 1);
    chk("R8 no reserved flag on error code", f_rsvd, 0);
    // R2 last start nibble wins, R3 glitch flagged
    step(1'b0, 4'h3);
    run_cycle(4'hD, 3'b000, 32'h00000CF8, 8'h11, 0, 4'h9, 4'hF, 1, 1);
    chk("R3 glitch flag", f_glitch, 1);
    // R4 abort start code: no record
    base = nrec;
    step(1'b0, 4'hF); step(1'b1, 4'h0);
    for (int i = 0; i < 12; i++) step(1'b1, 4'hF);
    chk("R4 no record on abort", nrec, base);
    // R5 disallowed kind
    chk("R5 bad kind clear", f_kind, 0);
    run_cycle(4'h0, 3'b110, 32'h0, 8'h00, 0, 4'h0, 4'hF, 0, 1);
    chk("R5 bad kind flag", f_kind, 1);
    // R5 DMA kind: no record
    run_cycle(4'h0, 3'b100, 32'h0, 8'h00, 0, 4'h0, 4'hF, 0, 1);
    chk("R5 no record for bad/DMA kinds", nrec, base);
    // R7 turnaround fault
    run_cycle(4'h0, 3'b001, 32'h000002E8, 8'h77, 0, 4'h0, 4'h7, 1, 1);
    chk("R7 turn flag", f_turn, 1);
    // R8 reserved sync
    run_cycle(4'h0, 3'b000, 32'h00000060, 8'hC3, 0, 4'h3, 4'hF, 1, 1);
    chk("R8 reserved sync flag", f_rsvd, 1);
    // R9 boundary: exactly the limit, then one more
    wait_limit = 8'd4;
    run_cycle(4'h0, 3'b010, 32'h12345678, 8'h9E, 4, 4'h0, 4'hF, 1, 1);
    chk("R9 limit waits accepted", f_tout, 0);
    base = nrec;
    run_cycle(4'h0, 3'b010, 32'h12345678, 8'h9E, 5, 4'h0, 4'hF, 0, 1);
    chk("R9 timeout flag", f_tout, 1);
    chk("R9 no record on timeout", nrec, base);
    // R12 frame low mid-address
    step(1'b0, 4'h0); step(1'b1, 4'b0100); step(1'b1, 4'h1); step(1'b1, 4'h2);
    run_cycle(4'h0, 3'b000, 32'h0000BEEF, 8'h42, 0, 4'h0, 4'hF, 1, 1);
    // R12 frame low on the final turnaround clock collides with completion
    base = nrec;
    run_cycle(4'h0, 3'b001, 32'h00001111, 8'h22, 0, 4'h0, 4'hF, 0, 0);
    run_cycle(4'h0, 3'b011, 32'hCAFEF00D, 8'hE1, 0, 4'h0, 4'hF, 1, 1);
    chk("R12 only restarted cycle recorded", nrec, base + 1);
    chk("R12 scoreboard drained", expq.size(), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule